// File: doc/BRIEF.md
# Iterative Integer Multiply-Divide Unit

This block computes 64-bit integer products and quotients for a processor pipeline over several clock cycles. One request is taken at a time through a valid/ready handshake. A request carries two operands, a 3-bit operation code and a word flag that selects 32-bit operation. When the work is done, the unit raises a response strobe for one cycle, with the result alongside it.

Products come from a shift-add loop that consumes `MUL_BITS` bits of the second operand per cycle. For signed operands, the top slice is given a negative weight, so signed and unsigned products take the same number of cycles. Both halves of the product are available once the loop ends. Quotients and remainders come from a restoring loop that resolves `DIV_BITS` quotient bits per cycle. That loop runs on operand magnitudes. Negative operands are made positive before it starts, and one extra cycle negates the result only when the sign rule demands it. An abort input drops the operation in flight.

Top module: `muldiv_iter`

## Requirements
- R1: Out of reset `req_ready` is 1 and `resp_valid` is 0. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only while the unit is idle. Each request that is taken and not aborted yields exactly one `resp_valid` pulse, one cycle wide.
- R2: The multiply opcodes are 0, 1, 2 and 3. Opcode 0 returns the low 64 bits of the product. Opcode 1 returns the high 64 bits with both operands signed. Opcode 2 returns the high 64 bits with A signed and B unsigned. Opcode 3 returns the high 64 bits with both operands unsigned.
- R3: With the word flag at 0, every multiply opcode raises `resp_valid` exactly XLEN/MUL_BITS clock edges after the accepting edge. This holds for the high-part opcodes too, and it does not depend on the sign of either operand.
- R4: With the word flag at 1, a multiply opcode returns bits 31..0 of the product, sign-extended from bit 31. It responds after half the iteration count of R3.
- R5: The divide opcodes are 4, 5, 6 and 7. Opcode 4 is a signed quotient, truncated toward zero. Opcode 5 is an unsigned quotient. Opcode 6 is a signed remainder, which takes the sign of the dividend. Opcode 7 is an unsigned remainder.
- R6: With the word flag at 0, a divide opcode responds XLEN/DIV_BITS edges after acceptance, plus one edge in two cases. The first case is opcode 4 when the operand signs differ and the divisor is nonzero. The second case is opcode 6 when the dividend is negative. No other case takes the extra edge.
- R7: With the word flag at 1, a divide opcode uses only bits 31..0 of each operand. It takes half the iteration count of R6, plus the same correction edge, with signs read from bit 31. The result is sign-extended from bit 31.
- R8: Division by zero returns all ones as the quotient (opcodes 4 and 5) and the dividend as the remainder (opcodes 6 and 7).
- R9: Signed overflow has the most negative dividend and a divisor of -1. In that case opcode 4 returns the dividend and opcode 6 returns zero, for both word widths.
- R10: An `abort` seen while the unit is busy returns it to idle on that edge: `req_ready` is 1 in the next cycle, and the dropped request produces no response. An `abort` seen while the unit is idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_op | input | 3 | Operation code (see R2, R5) |
| req_word | input | 1 | 32-bit operation, result sign-extended |
| req_a | input | XLEN | Multiplicand or dividend |
| req_b | input | XLEN | Multiplier or divisor |
| abort | input | 1 | Drop the operation in flight |
| resp_valid | output | 1 | Result strobe, one cycle |
| resp_data | output | XLEN | Result |

## Verification
The multiply opcodes are driven with pairs of operands whose signs vary: positive by positive, negative by positive, and both negative, including the most negative value. These pairs show whether the negative weight of the top slice is applied correctly, and whether the cycle count stays the same when the multiplier is negative. Word requests carry junk in bits 63..32 to expose any leak from the upper half. Divides are tried with every combination of operand signs, so that a correction cycle taken or skipped in the wrong case shows up as a latency error. Zero divisors and the overflow pair are also tried, and these separate the special-case results from ordinary wrap-around arithmetic. A long stream of mixed pseudo-random requests then runs back to back against a behavioural model, and aborts are placed both mid-operation and while idle.

// File: rtl/muldiv_iter.sv
module muldiv_iter #(
  parameter int XLEN     = 64,
  parameter int MUL_BITS = 8,
  parameter int DIV_BITS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      req_op,
  input  logic            req_word,
  input  logic [XLEN-1:0] req_a,
  input  logic [XLEN-1:0] req_b,
  input  logic            abort,
  output logic            resp_valid,
  output logic [XLEN-1:0] resp_data
);
  localparam int HALF      = XLEN / 2;
  localparam int PW        = 2 * XLEN;
  localparam int MUL_ITERS = XLEN / MUL_BITS;
  localparam int DIV_ITERS = XLEN / DIV_BITS;
  localparam int MAX_ITERS = (MUL_ITERS > DIV_ITERS) ? MUL_ITERS : DIV_ITERS;
  localparam int CW        = $clog2(MAX_ITERS + 1);
  localparam logic [CW-1:0] LAST = CW'(1);

  localparam logic [2:0] OP_MULH = 3'd1;
  localparam logic [2:0] OP_MULHSU = 3'd2;
  localparam logic [2:0] OP_DIV  = 3'd4;
  localparam logic [2:0] OP_REM  = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_MUL, S_DIV, S_NEG, S_DONE} state_t;

  state_t          state;
  logic [2:0]      op_q;
  logic            word_q;
  logic [CW-1:0]   cnt;
  logic [PW-1:0]   mcand, acc;
  logic [XLEN-1:0] mplier;
  logic            bneg_q;
  logic [XLEN:0]   rem_q;
  logic [XLEN-1:0] quo_q, dvsr_q;
  logic            fix_q;
  logic [XLEN-1:0] res_q;

  assign req_ready  = (state == S_IDLE);
  assign resp_valid = (state == S_DONE);
  assign resp_data  = word_q ? {{HALF{res_q[HALF-1]}}, res_q[HALF-1:0]} : res_q;

  logic is_div, a_sgn, b_sgn, a_neg, b_neg, b_zero, fix_sign;
  logic [XLEN-1:0] a_zx, b_zx, a_ng, b_ng, a_mag, b_mag;

  assign is_div = req_op[2];
  assign a_sgn  = is_div ? !req_op[0] : (req_op == OP_MULH || req_op == OP_MULHSU);
  assign b_sgn  = is_div ? !req_op[0] : (req_op == OP_MULH);
  assign a_neg  = a_sgn && (req_word ? req_a[HALF-1] : req_a[XLEN-1]);
  assign b_neg  = b_sgn && (req_word ? req_b[HALF-1] : req_b[XLEN-1]);
  assign a_zx   = req_word ? {{HALF{1'b0}}, req_a[HALF-1:0]} : req_a;
  assign b_zx   = req_word ? {{HALF{1'b0}}, req_b[HALF-1:0]} : req_b;
  assign a_ng   = -a_zx;
  assign b_ng   = -b_zx;
  assign a_mag  = !a_neg ? a_zx : (req_word ? {{HALF{1'b0}}, a_ng[HALF-1:0]} : a_ng);
  assign b_mag  = !b_neg ? b_zx : (req_word ? {{HALF{1'b0}}, b_ng[HALF-1:0]} : b_ng);
  assign b_zero = (b_zx == '0);
  assign fix_sign = (req_op == OP_DIV) ? ((a_neg ^ b_neg) && !b_zero)
                                       : ((req_op == OP_REM) && a_neg);

  logic [PW-1:0]   part, corr, acc_nx;
  logic [XLEN-1:0] mul_res;

  assign part    = mcand * {{(PW-MUL_BITS){1'b0}}, mplier[MUL_BITS-1:0]};
  assign corr    = (cnt == LAST && bneg_q) ? (mcand << MUL_BITS) : '0;
  assign acc_nx  = acc + part - corr;
  assign mul_res = (op_q[1:0] == 2'd0 || word_q) ? acc_nx[XLEN-1:0] : acc_nx[PW-1:XLEN];

  logic [XLEN:0]   rem_nx;
  logic [XLEN-1:0] quo_nx, div_raw;

  always_comb begin
    rem_nx = rem_q;
    quo_nx = quo_q;
    for (int i = 0; i < DIV_BITS; i++) begin
      rem_nx = {rem_nx[XLEN-1:0], quo_nx[XLEN-1]};
      quo_nx = {quo_nx[XLEN-2:0], 1'b0};
      if (rem_nx >= {1'b0, dvsr_q}) begin
        rem_nx    = rem_nx - {1'b0, dvsr_q};
        quo_nx[0] = 1'b1;
      end
    end
  end

  assign div_raw = op_q[1] ? rem_nx[XLEN-1:0] : quo_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_q   <= '0;
      word_q <= 1'b0;
      cnt    <= '0;
      mcand  <= '0;
      acc    <= '0;
      mplier <= '0;
      bneg_q <= 1'b0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvsr_q <= '0;
      fix_q  <= 1'b0;
      res_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          op_q   <= req_op;
          word_q <= req_word;
          if (is_div) begin
            state  <= S_DIV;
            cnt    <= req_word ? CW'(DIV_ITERS / 2) : CW'(DIV_ITERS);
            rem_q  <= '0;
            quo_q  <= req_word ? {a_mag[HALF-1:0], {HALF{1'b0}}} : a_mag;
            dvsr_q <= b_mag;
            fix_q  <= fix_sign;
          end else begin
            state  <= S_MUL;
            cnt    <= req_word ? CW'(MUL_ITERS / 2) : CW'(MUL_ITERS);
            acc    <= '0;
            mcand  <= {{XLEN{a_sgn && req_a[XLEN-1]}}, req_a};
            mplier <= req_b;
            bneg_q <= b_sgn && req_b[XLEN-1] && !req_word;
          end
        end
        S_MUL: if (abort) state <= S_IDLE;
        else begin
          acc    <= acc_nx;
          mcand  <= mcand << MUL_BITS;
          mplier <= mplier >> MUL_BITS;
          cnt    <= cnt - 1'b1;
          if (cnt == LAST) begin
            res_q <= mul_res;
            state <= S_DONE;
          end
        end
        S_DIV: if (abort) state <= S_IDLE;
        else begin
          rem_q <= rem_nx;
          quo_q <= quo_nx;
          cnt   <= cnt - 1'b1;
          if (cnt == LAST) begin
            res_q <= div_raw;
            state <= fix_q ? S_NEG : S_DONE;
          end
        end
        S_NEG: if (abort) state <= S_IDLE;
        else begin
          res_q <= -res_q;
          state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/muldiv_iter_chk.sv
module muldiv_iter_chk #(
  parameter int XLEN     = 64,
  parameter int MUL_BITS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [2:0]      req_op,
  input logic            req_word,
  input logic [XLEN-1:0] req_b,
  input logic            abort,
  input logic            resp_valid,
  input logic [XLEN-1:0] resp_data
);
  localparam int HALF = XLEN / 2;
  localparam logic [7:0] MUL_FULL = 8'(XLEN / MUL_BITS);
  localparam logic [7:0] MUL_WORD = 8'(XLEN / MUL_BITS / 2);

  logic [7:0] lat;
  logic [2:0] op_c;
  logic       word_c, bz_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat <= '0; op_c <= '0; word_c <= 1'b0; bz_c <= 1'b0;
    end else if (req_valid && req_ready) begin
      lat    <= '0;
      op_c   <= req_op;
      word_c <= req_word;
      bz_c   <= req_word ? (req_b[HALF-1:0] == '0) : (req_b == '0);
    end else if (lat != 8'hff) begin
      lat <= lat + 8'd1;
    end
  end

  p_one_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  p_busy_after_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_mul_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !op_c[2]) |-> (lat == (word_c ? MUL_WORD : MUL_FULL)));

  p_div_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && op_c[2:1] == 2'b10 && bz_c) |-> (resp_data == '1));

  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !req_ready) |=> (req_ready && !resp_valid));
endmodule

bind muldiv_iter muldiv_iter_chk #(.XLEN(XLEN), .MUL_BITS(MUL_BITS)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_word(req_word), .req_b(req_b), .abort(abort),
  .resp_valid(resp_valid), .resp_data(resp_data)
);

// File: tb/test_muldiv_iter.sv
`timescale 1ns/1ps
module test_muldiv_iter;
  localparam int MB = 8;
  localparam int DB = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic        req_word = 1'b0;
  logic [63:0] req_a = '0, req_b = '0;
  logic        abort = 1'b0;
  logic        resp_valid;
  logic [63:0] resp_data;

  muldiv_iter #(.XLEN(64), .MUL_BITS(MB), .DIV_BITS(DB)) i_muldiv_iter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_word(req_word), .req_a(req_a), .req_b(req_b),
    .abort(abort), .resp_valid(resp_valid), .resp_data(resp_data));

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0, n_fail = 0, n_unexp = 0;
  bit done = 0;

  logic [63:0] exp_q[$];
  int          lat_q[$];
  int          t0_q[$];
  string       dtag_q[$];
  string       ltag_q[$];

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [63:0] sx(logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] model(logic [2:0] op, logic w, logic [63:0] a, logic [63:0] b);
    logic [127:0] pa, pb, pp;
    logic [63:0]  q, r;
    logic [31:0]  p32, q32, r32, x32, y32;
    if (!op[2]) begin
      if (w) begin
        p32 = a[31:0] * b[31:0];
        return sx(p32);
      end
      pa = (op == 3'd1 || op == 3'd2) ? {{64{a[63]}}, a} : {64'b0, a};
      pb = (op == 3'd1) ? {{64{b[63]}}, b} : {64'b0, b};
      pp = pa * pb;
      return (op == 3'd0) ? pp[63:0] : pp[127:64];
    end
    if (w) begin
      x32 = a[31:0]; y32 = b[31:0];
      if (y32 == 0) begin q32 = '1; r32 = x32; end
      else if (!op[0] && x32 == 32'h8000_0000 && y32 == '1) begin q32 = x32; r32 = 0; end
      else if (!op[0]) begin q32 = $signed(x32) / $signed(y32); r32 = $signed(x32) % $signed(y32); end
      else begin q32 = x32 / y32; r32 = x32 % y32; end
      return op[1] ? sx(r32) : sx(q32);
    end
    if (b == 0) begin q = '1; r = a; end
    else if (!op[0] && a == 64'h8000_0000_0000_0000 && b == '1) begin q = a; r = 0; end
    else if (!op[0]) begin q = $signed(a) / $signed(b); r = $signed(a) % $signed(b); end
    else begin q = a / b; r = a % b; end
    return op[1] ? r : q;
  endfunction

  function automatic int lat_of(logic [2:0] op, logic w, logic [63:0] a, logic [63:0] b);
    logic an, bn, bz, neg;
    if (!op[2]) return w ? 64 / MB / 2 : 64 / MB;
    an  = !op[0] && (w ? a[31] : a[63]);
    bn  = !op[0] && (w ? b[31] : b[63]);
    bz  = w ? (b[31:0] == 0) : (b == 0);
    neg = (op == 3'd4) ? ((an ^ bn) && !bz) : ((op == 3'd6) && an);
    return (w ? 64 / DB / 2 : 64 / DB) + (neg ? 1 : 0);
  endfunction

  task automatic issue(logic [2:0] op, logic w, logic [63:0] a, logic [63:0] b, string dtag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_word = w; req_a = a; req_b = b;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    exp_q.push_back(model(op, w, a, b));
    lat_q.push_back(lat_of(op, w, a, b));
    t0_q.push_back(cyc);
    dtag_q.push_back(dtag);
    ltag_q.push_back(!op[2] ? (w ? "R4 latency" : "R3 latency") : (w ? "R7 latency" : "R6 latency"));
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_q.size() == 0) begin
        n_unexp++;
        check(1'b0, "R1 unexpected response", resp_data, '0);
      end else begin
        logic [63:0] e;
        int l, t;
        string dt, lt;
        e = exp_q.pop_front(); l = lat_q.pop_front(); t = t0_q.pop_front();
        dt = dtag_q.pop_front(); lt = ltag_q.pop_front();
        check(resp_data === e, dt, resp_data, e);
        check((cyc - t) == l, lt, 64'(cyc - t), 64'(l));
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #3000000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete (cycle %0d)", cyc);
      finish_run();
    end
  end

  localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONES = '1;

  initial begin
    logic [63:0] s;
    repeat (3) @(negedge clk);
    check(req_ready === 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
    check(resp_valid === 1'b0, "R1 reset no response", 64'(resp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1, "R1 idle after reset", 64'(req_ready), 64'd1);

    // R2/R3: multiply, sign mixes
    issue(3'd0, 0, 64'd3, 64'd5, "R2 MUL small");
    issue(3'd0, 0, -64'd7, 64'd9, "R2 MUL neg*pos");
    issue(3'd1, 0, ONES, ONES, "R2 MULH -1*-1");
    issue(3'd1, 0, MINV, MINV, "R2 MULH min*min");
    issue(3'd1, 0, 64'd12345, -64'd3, "R2 MULH pos*neg");
    issue(3'd1, 0, 64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210, "R2 MULH mixed");
    issue(3'd2, 0, ONES, ONES, "R2 MULHSU");
    issue(3'd2, 0, 64'h7fff_0000_1234_5678, ONES, "R2 MULHSU pos");
    issue(3'd3, 0, ONES, ONES, "R2 MULHU");
    // R4: word multiply with junk in the upper half
    issue(3'd0, 1, 64'hdead_beef_7fff_ffff, 64'h1234_5678_0000_0002, "R4 MULW");
    issue(3'd0, 1, 64'h0000_0001_ffff_fffd, 64'h0000_0000_0000_0003, "R4 MULW neg");
    // R5/R6: all sign combinations
    issue(3'd4, 0, 64'd20, -64'd3, "R5 DIV pos/neg");
    issue(3'd4, 0, -64'd20, -64'd3, "R5 DIV neg/neg");
    issue(3'd4, 0, -64'd20, 64'd3, "R5 DIV neg/pos");
    issue(3'd5, 0, ONES, 64'd7, "R5 DIVU");
    issue(3'd6, 0, -64'd20, 64'd3, "R5 REM neg dividend");
    issue(3'd6, 0, 64'd20, -64'd3, "R5 REM pos dividend");
    issue(3'd7, 0, ONES, 64'd10, "R5 REMU");
    // R7: word division
    issue(3'd4, 1, 64'hffff_0000_ffff_ffec, 64'h7777_7777_0000_0003, "R7 DIVW");
    issue(3'd6, 1, 64'h0000_0000_ffff_ffec, 64'h0000_0000_0000_0003, "R7 REMW");
    issue(3'd5, 1, 64'h1111_1111_ffff_fffe, 64'h0000_0000_0000_0002, "R7 DIVUW");
    issue(3'd7, 1, 64'h0000_0000_8000_0001, 64'hffff_ffff_0000_0010, "R7 REMUW");
    // R8: zero divisor
    issue(3'd4, 0, 64'd5, 64'd0, "R8 DIV by zero");
    issue(3'd4, 0, -64'd5, 64'd0, "R8 DIV neg by zero");
    issue(3'd5, 0, 64'd0, 64'd0, "R8 DIVU zero by zero");
    issue(3'd6, 0, -64'd5, 64'd0, "R8 REM by zero");
    issue(3'd7, 0, 64'd99, 64'd0, "R8 REMU by zero");
    issue(3'd4, 1, 64'h0000_0000_ffff_fffb, 64'hffff_ffff_0000_0000, "R8 DIVW by zero");
    issue(3'd6, 1, 64'h0000_0000_ffff_fffb, 64'h0000_0001_0000_0000, "R8 REMW by zero");
    // R9: overflow
    issue(3'd4, 0, MINV, ONES, "R9 DIV overflow");
    issue(3'd6, 0, MINV, ONES, "R9 REM overflow");
    issue(3'd4, 1, 64'h0000_0000_8000_0000, ONES, "R9 DIVW overflow");
    issue(3'd6, 1, 64'h0000_0000_8000_0000, ONES, "R9 REMW overflow");
    drain();

    // R10: abort mid-divide, then check that nothing arrives
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd4; req_word = 1'b0; req_a = -64'd1000; req_b = 64'd7;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check(req_ready === 1'b1, "R10 ready after abort", 64'(req_ready), 64'd1);
    repeat (40) @(negedge clk);
    check(n_unexp == 0, "R10 no response after abort", 64'(n_unexp), 64'd0);
    // R10: abort mid-multiply
    req_valid = 1'b1; req_op = 3'd1; req_word = 1'b0; req_a = 64'd3; req_b = 64'd4;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check(req_ready === 1'b1, "R10 ready after mul abort", 64'(req_ready), 64'd1);
    repeat (12) @(negedge clk);
    check(n_unexp == 0, "R10 no mul response after abort", 64'(n_unexp), 64'd0);
    // R10: abort while idle has no effect
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check(req_ready === 1'b1 && resp_valid === 1'b0, "R10 idle abort ignored",
          {62'd0, req_ready, resp_valid}, 64'd2);
    issue(3'd6, 0, -64'd1000, 64'd7, "R10 request after idle abort");
    drain();

    // Mixed stream against the model
    s = 64'h9e37_79b9_7f4a_7c15;
    for (int i = 0; i < 60; i++) begin
      logic [63:0] a, b;
      logic [2:0] op;
      logic w;
      s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
      op = s[2:0]; w = s[3];
      a = s;
      s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
      b = (s[5:4] == 2'd0) ? 64'd0 : (s >> s[11:6]);
      if (s[12]) b = -b;
      issue(op, w, a, b, !op[2] ? (w ? "R4 mixed" : "R2 mixed") : (w ? "R7 mixed" : "R5 mixed"));
    end
    drain();

    done = 1;
    finish_run();
  end
endmodule